// File: doc/BRIEF.md
# Skewed Lockstep Output Comparator

This block watches two execution cores that run the same instruction stream, one of them (the shadow) trailing the other (the primary) by a fixed skew of one or two clock cycles. The primary's output bus and its valid qualifier pass through a delay line as deep as the skew, so each shadow output meets the primary output it should equal. Every cycle the two aligned streams are compared lane by lane. Any disagreement raises a trap in hardware, with no software step in between.

The skew makes a disturbance that hits both cores at the same instant, such as a supply glitch, land on different points of the instruction stream. It then appears as a mismatch rather than as two identical wrong results. A fault-injection input flips one chosen bit of the shadow stream just before the comparison. This lets the comparator itself be tested for latent faults. The trap is a one-cycle pulse on the first mismatch. A sticky error flag and the number of the first failing lane stay set until an explicit clear.

The output bus is split into `LANES` lanes of `LANE_W` bits. Lane i is bits `[i*LANE_W +: LANE_W]`. `SKEW` may be 1 or 2.

Top module: `lockstep_cmp`

## Requirements
- R1: The shadow inputs presented in cycle k are compared with the primary inputs presented in cycle k-SKEW. Two identical streams skewed by exactly SKEW cycles never raise a trap.
- R2: A compared mismatch in cycle k drives `trap` high in cycle k+1 only (one clock edge later), when no error is already held.
- R3: `err_sticky` rises together with `trap` and stays high until a cycle with `err_clr` high.
- R4: `err_lane` takes the lowest-numbered lane whose data differ, captured at the trap, and holds while the error is held.
- R5: If the delayed primary valid and the shadow valid differ, this counts as a mismatch and `err_lane` is set to the value LANES.
- R6: In a cycle where both aligned valid bits are low, the data buses are ignored and no trap follows.
- R7: No comparison takes place during the first SKEW cycles after reset is released.
- R8: With `inj_en` high, bit `inj_sel` of the shadow data is inverted before comparison, so a fault in lane inj_sel/LANE_W is reported.
- R9: During and right after reset, `trap`, `err_sticky` and `err_lane` are all zero.
- R10: If `err_clr` and a new mismatch occur in the same cycle, the new mismatch is recorded and `trap` pulses again.
- R11: While an error is held and not being cleared, further mismatches raise no trap and leave `err_lane` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pri_vld | input | 1 | Primary core output valid |
| pri_data | input | LANES*LANE_W | Primary core output bus |
| shd_vld | input | 1 | Shadow core output valid |
| shd_data | input | LANES*LANE_W | Shadow core output bus |
| inj_en | input | 1 | Invert one shadow bit this cycle |
| inj_sel | input | $clog2(LANES*LANE_W) | Bit to invert |
| err_clr | input | 1 | Clear the held error |
| trap | output | 1 | One-cycle pulse on the first mismatch |
| err_sticky | output | 1 | Error held since the last clear |
| err_lane | output | $clog2(LANES+1) | First failing lane; LANES means valid disagreement |

## Verification
A delay line that is one stage too short or too long shows up at the ports at once: streams that match under the right skew raise a trap one cycle after the first valid word is compared. A wrong lane priority or a valid-disagreement code gives a wrong `err_lane` in the cycle of the trap. A sticky flag that drops early, or re-arms while held, shows as a missing or extra `trap` pulse on the next mismatch. An arming counter that opens too early traps within the first SKEW+1 cycles after reset.

// File: rtl/lsc_pkg.sv
// Shared helpers for the skewed lockstep comparator.
// Assumes: lane counts are small positive integers.
package lsc_pkg;

    // Width of a lane index that can also encode the valid-disagreement code.
    function automatic int lane_idx_width(input int lanes);
        return (lanes < 1) ? 1 : $clog2(lanes + 1);
    endfunction

    // Width of a counter that can reach the given value.
    function automatic int count_width(input int max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/lsc_delay_line.sv
// Fixed-depth register delay line.
// Does: presents its input DEPTH clock edges later; all stages reset to zero.
// Assumes: DEPTH >= 1.
module lsc_delay_line #(
    parameter int W     = 33,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stg [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        if (i == 0) begin : g_head
            // Capture the live input into the first stage.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[i] <= '0;
                else        stg[i] <= din;
            end
        end else begin : g_tail
            // Shift the previous stage forward.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[i] <= '0;
                else        stg[i] <= stg[i-1];
            end
        end
    end

    assign dout = stg[DEPTH-1];

endmodule

// File: rtl/lsc_arm_ctrl.sv
// Comparison arming after reset.
// Does: raises armed once SKEW clock edges have passed since reset release,
// i.e. once the delay line holds only post-reset primary samples.
// Assumes: SKEW >= 1.
module lsc_arm_ctrl #(
    parameter int SKEW = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic armed
);

    localparam int CW = lsc_pkg::count_width(SKEW);

    logic [CW-1:0] fill_cnt;

    assign armed = (fill_cnt == CW'(SKEW));

    // Count edges since reset until the delay line is full, then hold.
    always_ff @(posedge clk) begin
        if (!rst_n)      fill_cnt <= '0;
        else if (!armed) fill_cnt <= fill_cnt + 1'b1;
    end

endmodule

// File: rtl/lsc_lane_cmp.sv
// Aligned stream comparator.
// Does: compares two valid-qualified buses lane by lane; reports a mismatch
// and the lowest failing lane, or code LANES when the valid bits disagree.
// Assumes: both inputs are already time-aligned; purely combinational.
module lsc_lane_cmp #(
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    parameter int IDX_W  = 3
) (
    input  logic                    armed,
    input  logic                    a_vld,
    input  logic [LANES*LANE_W-1:0] a_data,
    input  logic                    b_vld,
    input  logic [LANES*LANE_W-1:0] b_data,
    output logic                    mismatch,
    output logic [IDX_W-1:0]        idx
);

    logic [LANES-1:0] lane_diff;
    logic             vld_diff;
    logic             both_vld;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lane_diff[l] = |(a_data[l*LANE_W +: LANE_W] ^ b_data[l*LANE_W +: LANE_W]);
    end

    assign vld_diff = a_vld ^ b_vld;
    assign both_vld = a_vld & b_vld;

    // Pick the lowest differing lane; a valid disagreement overrides it.
    always_comb begin
        idx = '0;
        for (int l = LANES - 1; l >= 0; l--) begin
            if (lane_diff[l]) idx = IDX_W'(l);
        end
        if (vld_diff) idx = IDX_W'(LANES);
        mismatch = armed & (vld_diff | (both_vld & (|lane_diff)));
    end

endmodule

// File: rtl/lsc_fault_latch.sv
// Trap and sticky error capture.
// Does: on a mismatch with no error held, pulses trap for one cycle, sets
// the sticky flag and records the lane; clear releases the held error, and
// a mismatch in the clearing cycle is recorded afresh.
// Assumes: mismatch and idx are stable before the clock edge.
module lsc_fault_latch #(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mismatch,
    input  logic [IDX_W-1:0] idx,
    input  logic             clr,
    output logic             trap,
    output logic             sticky,
    output logic [IDX_W-1:0] lane
);

    logic keep;

    assign keep = sticky & ~clr;

    // Record the first mismatch and pulse the trap; otherwise hold or clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap   <= 1'b0;
            sticky <= 1'b0;
            lane   <= '0;
        end else if (mismatch && !keep) begin
            trap   <= 1'b1;
            sticky <= 1'b1;
            lane   <= idx;
        end else begin
            trap   <= 1'b0;
            sticky <= keep;
        end
    end

endmodule

// File: rtl/lockstep_cmp.sv
// Skewed dual-core lockstep comparator (top).
// Does: delays the primary outputs by SKEW cycles, applies optional
// single-bit fault injection to the shadow outputs, compares the aligned
// streams and latches the first failure.
// Assumes: SKEW is 1 or 2; the shadow core trails the primary by SKEW cycles.
module lockstep_cmp #(
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    parameter int SKEW   = 2
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                pri_vld,
    input  logic [LANES*LANE_W-1:0]             pri_data,
    input  logic                                shd_vld,
    input  logic [LANES*LANE_W-1:0]             shd_data,
    input  logic                                inj_en,
    input  logic [$clog2(LANES*LANE_W)-1:0]     inj_sel,
    input  logic                                err_clr,
    output logic                                trap,
    output logic                                err_sticky,
    output logic [$clog2(LANES+1)-1:0]          err_lane
);

    localparam int DATA_W = LANES * LANE_W;
    localparam int IDX_W  = lsc_pkg::lane_idx_width(LANES);

    logic [DATA_W:0]   pri_dly;
    logic [DATA_W-1:0] inj_mask;
    logic [DATA_W-1:0] shd_eff;
    logic              armed;
    logic              mismatch;
    logic [IDX_W-1:0]  mm_idx;

    // Build the single-bit fault mask and apply it to the shadow stream.
    always_comb begin
        inj_mask = inj_en ? (DATA_W'(1) << inj_sel) : '0;
        shd_eff  = shd_data ^ inj_mask;
    end

    lsc_delay_line #(
        .W     (DATA_W + 1),
        .DEPTH (SKEW)
    ) i_delay (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({pri_vld, pri_data}),
        .dout  (pri_dly)
    );

    lsc_arm_ctrl #(
        .SKEW (SKEW)
    ) i_arm (
        .clk   (clk),
        .rst_n (rst_n),
        .armed (armed)
    );

    lsc_lane_cmp #(
        .LANES  (LANES),
        .LANE_W (LANE_W),
        .IDX_W  (IDX_W)
    ) i_cmp (
        .armed    (armed),
        .a_vld    (pri_dly[DATA_W]),
        .a_data   (pri_dly[DATA_W-1:0]),
        .b_vld    (shd_vld),
        .b_data   (shd_eff),
        .mismatch (mismatch),
        .idx      (mm_idx)
    );

    lsc_fault_latch #(
        .IDX_W (IDX_W)
    ) i_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .mismatch (mismatch),
        .idx      (mm_idx),
        .clr      (err_clr),
        .trap     (trap),
        .sticky   (err_sticky),
        .lane     (err_lane)
    );

endmodule

// File: rtl/lsc_checker.sv
// Assertion checker for lockstep_cmp, attached with bind.
// Does: checks trap pulse shape, sticky behaviour, lane hold and arming.
module lsc_checker #(
    parameter int LANES = 4,
    parameter int SKEW  = 2,
    parameter int IDX_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             err_clr,
    input logic             trap,
    input logic             err_sticky,
    input logic [IDX_W-1:0] err_lane
);

    localparam int CW = lsc_pkg::count_width(SKEW);

    logic [CW-1:0] since_rst;

    // Count edges since reset release, saturating at SKEW.
    always_ff @(posedge clk) begin
        if (!rst_n)                     since_rst <= '0;
        else if (since_rst != CW'(SKEW)) since_rst <= since_rst + 1'b1;
    end

    // R2: the trap lasts one cycle unless a clear re-arms it.
    a_r2_trap_single: assert property (@(posedge clk) disable iff (!rst_n)
        trap && !err_clr |=> !trap);

    // R2: the flag cannot rise without a trap.
    a_r2_rise_has_trap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_sticky) |-> trap);

    // R3: every trap is accompanied by the sticky flag.
    a_r3_trap_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> err_sticky);

    // R3: the flag holds until cleared.
    a_r3_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        err_sticky && !err_clr |=> err_sticky);

    // R4: the recorded lane holds while the error is held.
    a_r4_lane_holds: assert property (@(posedge clk) disable iff (!rst_n)
        err_sticky && !err_clr |=> $stable(err_lane));

    // R5: the lane code never exceeds the disagreement code.
    a_r5_lane_range: assert property (@(posedge clk) disable iff (!rst_n)
        err_lane <= IDX_W'(LANES));

    // R7: no trap can follow a cycle before the delay line is full.
    a_r7_no_early_trap: assert property (@(posedge clk) disable iff (!rst_n)
        since_rst != CW'(SKEW) |=> !trap);

    // R11: no second trap while an error is held.
    a_r11_no_retrap: assert property (@(posedge clk) disable iff (!rst_n)
        err_sticky && !err_clr |=> !trap);

endmodule

bind lockstep_cmp lsc_checker #(
    .LANES (LANES),
    .SKEW  (SKEW),
    .IDX_W (IDX_W)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .err_clr    (err_clr),
    .trap       (trap),
    .err_sticky (err_sticky),
    .err_lane   (err_lane)
);

// File: tb/test_lockstep_cmp.sv
`timescale 1ns/1ps
module test_lockstep_cmp;

    localparam int LANES  = 4;
    localparam int LANE_W = 8;
    localparam int SKEW   = 2;
    localparam int DW     = LANES * LANE_W;
    localparam int NTAB   = 12;

    // pv: primary valid; pd: data; sflip: invert shadow valid;
    // smask: XOR onto shadow data; clr: err_clr in the shadow cycle.
    typedef struct packed {
        logic          pv;
        logic [DW-1:0] pd;
        logic          sflip;
        logic [DW-1:0] smask;
        logic          clr;
    } vec_t;

    localparam vec_t TAB [NTAB] = '{
        '{1'b1, 32'h11223344, 1'b0, 32'h00000000, 1'b0},
        '{1'b1, 32'hA5A5A5A5, 1'b0, 32'h00000000, 1'b0},
        '{1'b0, 32'hDEAD0000, 1'b0, 32'h00000000, 1'b0},
        '{1'b1, 32'h00000001, 1'b0, 32'h00000100, 1'b0},
        '{1'b1, 32'hFFFFFFFF, 1'b0, 32'h01000000, 1'b0},
        '{1'b1, 32'h12345678, 1'b0, 32'h00000000, 1'b1},
        '{1'b1, 32'h87654321, 1'b0, 32'h80000001, 1'b0},
        '{1'b1, 32'h00000000, 1'b1, 32'h00000000, 1'b1},
        '{1'b0, 32'hCAFEBABE, 1'b0, 32'hFFFFFFFF, 1'b1},
        '{1'b1, 32'h0F0F0F0F, 1'b0, 32'h00000000, 1'b0},
        '{1'b1, 32'hF0F0F0F0, 1'b0, 32'h00FF0000, 1'b0},
        '{1'b1, 32'h00000000, 1'b0, 32'h00000000, 1'b1}
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic          pri_vld, shd_vld, inj_en, err_clr;
    logic [DW-1:0] pri_data, shd_data;
    logic [4:0]    inj_sel;
    logic          trap, err_sticky;
    logic [2:0]    err_lane;

    int checks = 0;
    int errors = 0;

    // Bench model state
    logic [DW:0] hist [SKEW];
    int          cyc;
    logic        exp_trap, exp_sticky;
    logic [2:0]  exp_lane;

    always #5 clk = ~clk;

    lockstep_cmp #(.LANES(LANES), .LANE_W(LANE_W), .SKEW(SKEW)) i_lockstep_cmp (
        .clk(clk), .rst_n(rst_n),
        .pri_vld(pri_vld), .pri_data(pri_data),
        .shd_vld(shd_vld), .shd_data(shd_data),
        .inj_en(inj_en), .inj_sel(inj_sel), .err_clr(err_clr),
        .trap(trap), .err_sticky(err_sticky), .err_lane(err_lane)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // One cycle: drive at negedge, model at posedge, check at next negedge.
    task automatic step(input string tag, input logic pv, input logic [DW-1:0] pd,
                        input logic sv, input logic [DW-1:0] sd, input logic clr,
                        input logic ie, input logic [4:0] is);
        logic          mm;
        logic [2:0]    ln;
        logic [DW-1:0] eff;
        logic          keep;
        pri_vld = pv; pri_data = pd; shd_vld = sv; shd_data = sd;
        err_clr = clr; inj_en = ie; inj_sel = is;
        eff = sd ^ (ie ? (32'(1) << is) : 32'h0);
        mm = 1'b0; ln = 3'd0;
        if (cyc >= SKEW) begin
            if (hist[SKEW-1][DW] != sv) begin
                mm = 1'b1; ln = 3'(LANES);
            end else if (sv && (hist[SKEW-1][DW-1:0] != eff)) begin
                mm = 1'b1;
                for (int l = LANES - 1; l >= 0; l--)
                    if (hist[SKEW-1][l*LANE_W +: LANE_W] != eff[l*LANE_W +: LANE_W]) ln = 3'(l);
            end
        end
        @(posedge clk);
        keep = exp_sticky && !clr;
        if (mm && !keep) begin
            exp_trap = 1'b1; exp_sticky = 1'b1; exp_lane = ln;
        end else begin
            exp_trap = 1'b0; exp_sticky = keep;
        end
        for (int i = SKEW - 1; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = {pv, pd};
        cyc++;
        @(negedge clk);
        chk(tag, "trap", 32'(trap), 32'(exp_trap));
        chk(tag, "err_sticky", 32'(err_sticky), 32'(exp_sticky));
        chk(tag, "err_lane", 32'(err_lane), 32'(exp_lane));
    endtask

    task automatic idle(input string tag);
        step(tag, 1'b0, '0, 1'b0, '0, 1'b0, 1'b0, 5'd0);
    endtask

    // Send a primary word and its shadow copy SKEW cycles later.
    task automatic pair(input string tag, input logic pv, input logic [DW-1:0] pd,
                        input logic sflip, input logic [DW-1:0] smask, input logic clr,
                        input logic ie, input logic [4:0] is);
        step(tag, pv, pd, 1'b0, '0, 1'b0, 1'b0, 5'd0);
        for (int i = 1; i < SKEW; i++) idle(tag);
        step(tag, 1'b0, '0, pv ^ sflip, pd ^ smask, clr, ie, is);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        pri_vld = 1'b0; pri_data = '0; shd_vld = 1'b0; shd_data = '0;
        err_clr = 1'b0; inj_en = 1'b0; inj_sel = '0;
        for (int i = 0; i < SKEW; i++) hist[i] = '0;
        cyc = 0; exp_trap = 1'b0; exp_sticky = 1'b0; exp_lane = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R9", "trap in reset", 32'(trap), 32'h0);
        chk("R9", "sticky in reset", 32'(err_sticky), 32'h0);
        chk("R9", "lane in reset", 32'(err_lane), 32'h0);
        rst_n = 1'b1;
    endtask

    // Watchdog
    initial begin
        #2_000_000;
        errors++;
        $display("FAIL R1 watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();

        // R7: shadow garbage during the fill window must not trap.
        for (int i = 0; i < SKEW; i++)
            step("R7", 1'b0, '0, 1'b1, 32'hFFFFFFFF, 1'b0, 1'b0, 5'd0);
        chk("R7", "no trap during fill", 32'(err_sticky), 32'h0);

        // R1: table of skewed streams walked by one loop.
        for (int k = 0; k < NTAB + SKEW; k++) begin
            logic          pv, sv, cl;
            logic [DW-1:0] pd, sd;
            pv = 1'b0; pd = '0; sv = 1'b0; sd = '0; cl = 1'b0;
            if (k < NTAB) begin pv = TAB[k].pv; pd = TAB[k].pd; end
            if (k >= SKEW) begin
                sv = TAB[k-SKEW].pv ^ TAB[k-SKEW].sflip;
                sd = TAB[k-SKEW].pd ^ TAB[k-SKEW].smask;
                cl = TAB[k-SKEW].clr;
            end
            step("R1", pv, pd, sv, sd, cl, 1'b0, 5'd0);
        end
        idle("R1");

        // R8: inject bit 13 (lane 1) on an otherwise matching stream.
        pair("R8", 1'b1, 32'h5A5A5A5A, 1'b0, '0, 1'b0, 1'b1, 5'd13);
        chk("R8", "trap on injection", 32'(trap), 32'h1);
        chk("R4", "lane of injected bit", 32'(err_lane), 32'h1);
        // R2: pulse lasts one cycle.
        idle("R2");
        chk("R2", "trap dropped", 32'(trap), 32'h0);
        chk("R3", "flag held", 32'(err_sticky), 32'h1);

        // R11: second mismatch while held gives no trap.
        pair("R11", 1'b1, 32'h01020304, 1'b0, 32'hFF000000, 1'b0, 1'b0, 5'd0);
        chk("R11", "no retrap", 32'(trap), 32'h0);
        chk("R11", "lane kept", 32'(err_lane), 32'h1);

        // R3: clear releases the flag.
        step("R3", 1'b0, '0, 1'b0, '0, 1'b1, 1'b0, 5'd0);
        chk("R3", "cleared", 32'(err_sticky), 32'h0);

        // R6: both invalid with differing data.
        pair("R6", 1'b0, 32'h13572468, 1'b0, 32'hFFFF0000, 1'b0, 1'b0, 5'd0);
        chk("R6", "no trap", 32'(trap), 32'h0);

        // R5: valid disagreement reports lane code LANES.
        pair("R5", 1'b1, 32'hAAAA5555, 1'b1, '0, 1'b0, 1'b0, 5'd0);
        chk("R5", "trap on valid diff", 32'(trap), 32'h1);
        chk("R5", "lane code", 32'(err_lane), 32'(LANES));

        // R10: clear and a fresh mismatch in one cycle.
        pair("R10", 1'b1, 32'h00000000, 1'b0, 32'h00010000, 1'b1, 1'b0, 5'd0);
        chk("R10", "trap again", 32'(trap), 32'h1);
        chk("R10", "new lane", 32'(err_lane), 32'h2);

        // R9: reset in the middle clears everything.
        do_reset();
        idle("R9");
        chk("R9", "after reset", 32'(err_sticky), 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule